// File: doc/BRIEF.md
# Fetch Thread Selector for a Simultaneous Multithreading Core

This block decides, every cycle, which hardware thread contexts of a multithreaded core may fetch instructions and how many fetch slots each one gets. It keeps three small counters per thread: instructions fetched but not yet issued, branches not yet resolved, and data-cache misses not yet serviced. The pipeline raises and lowers these counters with single-cycle pulses. The block then ranks the eligible threads by the counter that the selected policy names. The lowest count wins. Equal counts are settled by a rotating pointer. The two best threads are granted a share of the fixed fetch width.

The ranking policy and the slot-split policy are chosen independently. Under plain rotation all counts are treated as equal, so only the pointer orders the threads. The slot split is one of three: one thread takes every slot; two threads take half each; or the first thread takes as many as it can deliver and the second fills the rest. The grants are registered and appear one clock after the inputs they were computed from.

Top module: `fetch_sel`

## Requirements
- R1: While `rst` is high at a rising edge, both grants are invalid with zero thread ID and zero slots after that edge. All counters clear to zero and the rotation pointer returns to thread 0.
- R2: A thread whose valid flag is low, whose stall flag is high, or whose instruction-cache-miss flag is high is never granted.
- R3: With `key_mode` = 0 (rotation), grants go to eligible threads in circular order starting at the rotation pointer. After each cycle with a grant, the pointer moves to the thread after the last granted thread: the second grant in the two-thread splits, otherwise the first.
- R4: With `key_mode` = 1, the thread with the fewest unissued instructions is ranked first.
- R5: With `key_mode` = 2, the thread with the fewest unresolved branches is ranked first.
- R6: With `key_mode` = 3, the thread with the fewest outstanding data-cache misses is ranked first.
- R7: Among threads with equal counts, the one reached first going circularly from the rotation pointer wins.
- R8: With `split_mode` = 0 or 3, only the first grant is used and it carries all FW slots. The second grant is invalid.
- R9: With `split_mode` = 1 and two eligible threads, each grant carries FW/2 slots.
- R10: With `split_mode` = 2 and two eligible threads, the first grant carries min(its avail, FW) slots. The second grant carries min(its avail, FW minus the first grant's slots).
- R11: With one eligible thread, the first grant carries all FW slots and the second is invalid. With none eligible, both grants are invalid. The two grants never name the same thread.
- R12: Each counter stops at its maximum value (2^CW-1) and never drops below zero. An increment and a decrement in the same cycle leave it unchanged.
- R13: Grants are registered. They reflect the inputs and counter values present at the preceding rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_mode | input | 2 | Ranking policy: 0 rotation, 1 unissued, 2 branches, 3 misses |
| split_mode | input | 2 | Slot split: 0/3 one thread, 1 halves, 2 wide fill |
| thr_valid | input | NT | Thread context is active |
| thr_stall | input | NT | Thread is stalled |
| thr_imiss | input | NT | Thread waits on an instruction-cache miss |
| avail | input | NT*SW | Per-thread count of instructions the thread can deliver this cycle |
| ic_inc | input | NT | Unissued-instruction counter increment pulse |
| ic_dec | input | NT | Unissued-instruction counter decrement pulse |
| br_inc | input | NT | Unresolved-branch counter increment pulse |
| br_dec | input | NT | Unresolved-branch counter decrement pulse |
| ms_inc | input | NT | Outstanding-miss counter increment pulse |
| ms_dec | input | NT | Outstanding-miss counter decrement pulse |
| g0_vld | output | 1 | First grant valid |
| g0_tid | output | TW | First grant thread ID |
| g0_slots | output | SW | First grant slot count |
| g1_vld | output | 1 | Second grant valid |
| g1_tid | output | TW | Second grant thread ID |
| g1_slots | output | SW | Second grant slot count |

## Verification
The assertions assume that the mode inputs and eligibility flags sampled at an edge belong to the grants that appear after that edge. For this reason the checker keeps its own one-cycle copies of those inputs, and no other pipeline is allowed between the stimulus and the ports. They also assume `avail` values above FW may occur. The slot checks therefore rely on clipping, not on well-formed inputs. The stimulus changes all inputs only at the falling edge. It mixes random eligibility, random count pulses and random avail values from 0 to 15 with directed runs that drive counters into saturation and below zero.

// File: rtl/fs_pkg.sv
package fs_pkg;
  typedef enum logic [1:0] {
    KEY_ROT  = 2'd0,
    KEY_ICNT = 2'd1,
    KEY_BR   = 2'd2,
    KEY_MISS = 2'd3
  } key_e;

  typedef enum logic [1:0] {
    SPL_ONE  = 2'd0,
    SPL_HALF = 2'd1,
    SPL_WIDE = 2'd2,
    SPL_RSV  = 2'd3
  } split_e;
endpackage

// File: rtl/fs_sat_ctr.sv
module fs_sat_ctr #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  input  logic          dec,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] MAXV = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (inc && !dec) begin
      if (cnt != MAXV) cnt <= cnt + 1'b1;
    end else if (dec && !inc) begin
      if (cnt != '0) cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/fs_pick.sv
module fs_pick #(
  parameter int NT = 8,
  parameter int CW = 5,
  localparam int TW = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic [NT-1:0]    elig,
  input  logic [NT*CW-1:0] keys,
  input  logic [TW-1:0]    start,
  output logic             found,
  output logic [TW-1:0]    tid
);
  logic [CW-1:0] best;

  always_comb begin
    found = 1'b0;
    tid   = '0;
    best  = '1;
    for (int k = 0; k < NT; k++) begin
      int idx;
      idx = (int'(start) + k) % NT;
      if (elig[idx] && (!found || keys[idx*CW +: CW] < best)) begin
        found = 1'b1;
        tid   = TW'(idx);
        best  = keys[idx*CW +: CW];
      end
    end
  end
endmodule

// File: rtl/fetch_sel.sv
module fetch_sel
  import fs_pkg::*;
#(
  parameter int NT = 8,
  parameter int FW = 8,
  parameter int CW = 5,
  localparam int TW = (NT > 1) ? $clog2(NT) : 1,
  localparam int SW = $clog2(FW + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      key_mode,
  input  logic [1:0]      split_mode,
  input  logic [NT-1:0]   thr_valid,
  input  logic [NT-1:0]   thr_stall,
  input  logic [NT-1:0]   thr_imiss,
  input  logic [NT*SW-1:0] avail,
  input  logic [NT-1:0]   ic_inc,
  input  logic [NT-1:0]   ic_dec,
  input  logic [NT-1:0]   br_inc,
  input  logic [NT-1:0]   br_dec,
  input  logic [NT-1:0]   ms_inc,
  input  logic [NT-1:0]   ms_dec,
  output logic            g0_vld,
  output logic [TW-1:0]   g0_tid,
  output logic [SW-1:0]   g0_slots,
  output logic            g1_vld,
  output logic [TW-1:0]   g1_tid,
  output logic [SW-1:0]   g1_slots
);
  localparam logic [SW-1:0] FULL = SW'(FW);
  localparam logic [SW-1:0] HALF = SW'(FW / 2);

  logic [NT*CW-1:0] ic_cnt, br_cnt, ms_cnt, key_flat;
  logic [NT-1:0]    elig, elig_b;
  logic [TW-1:0]    rot_ptr, ptr_nxt;
  logic             f0, f1;
  logic [TW-1:0]    t0, t1;
  logic [SW-1:0]    s0, s1, av0, av1;
  logic             two_way;

  assign elig = thr_valid & ~thr_stall & ~thr_imiss;

  for (genvar t = 0; t < NT; t++) begin : g_thr
    fs_sat_ctr #(.CW(CW)) u_ic (
      .clk(clk), .rst(rst), .inc(ic_inc[t]), .dec(ic_dec[t]),
      .cnt(ic_cnt[t*CW +: CW]));
    fs_sat_ctr #(.CW(CW)) u_br (
      .clk(clk), .rst(rst), .inc(br_inc[t]), .dec(br_dec[t]),
      .cnt(br_cnt[t*CW +: CW]));
    fs_sat_ctr #(.CW(CW)) u_ms (
      .clk(clk), .rst(rst), .inc(ms_inc[t]), .dec(ms_dec[t]),
      .cnt(ms_cnt[t*CW +: CW]));

    always_comb begin
      unique case (key_e'(key_mode))
        KEY_ICNT: key_flat[t*CW +: CW] = ic_cnt[t*CW +: CW];
        KEY_BR:   key_flat[t*CW +: CW] = br_cnt[t*CW +: CW];
        KEY_MISS: key_flat[t*CW +: CW] = ms_cnt[t*CW +: CW];
        default:  key_flat[t*CW +: CW] = '0;
      endcase
    end
  end

  fs_pick #(.NT(NT), .CW(CW)) u_pick0 (
    .elig(elig), .keys(key_flat), .start(rot_ptr), .found(f0), .tid(t0));

  always_comb begin
    elig_b = elig;
    elig_b[t0] = 1'b0;
  end

  fs_pick #(.NT(NT), .CW(CW)) u_pick1 (
    .elig(elig_b), .keys(key_flat), .start(rot_ptr), .found(f1), .tid(t1));

  assign two_way = (split_e'(split_mode) == SPL_HALF) ||
                   (split_e'(split_mode) == SPL_WIDE);

  always_comb begin
    av0 = avail[t0*SW +: SW];
    av1 = avail[t1*SW +: SW];
    s0  = FULL;
    s1  = '0;
    if (two_way && f0 && f1) begin
      if (split_e'(split_mode) == SPL_HALF) begin
        s0 = HALF;
        s1 = HALF;
      end else begin
        s0 = (av0 > FULL) ? FULL : av0;
        s1 = (av1 > (FULL - s0)) ? (FULL - s0) : av1;
      end
    end
  end

  always_comb begin
    ptr_nxt = rot_ptr;
    if (two_way && f0 && f1)
      ptr_nxt = TW'((int'(t1) + 1) % NT);
    else if (f0)
      ptr_nxt = TW'((int'(t0) + 1) % NT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rot_ptr  <= '0;
      g0_vld   <= 1'b0;
      g0_tid   <= '0;
      g0_slots <= '0;
      g1_vld   <= 1'b0;
      g1_tid   <= '0;
      g1_slots <= '0;
    end else begin
      rot_ptr  <= ptr_nxt;
      g0_vld   <= f0;
      g0_tid   <= f0 ? t0 : '0;
      g0_slots <= f0 ? s0 : '0;
      g1_vld   <= two_way && f0 && f1;
      g1_tid   <= (two_way && f0 && f1) ? t1 : '0;
      g1_slots <= (two_way && f0 && f1) ? s1 : '0;
    end
  end
endmodule

// File: rtl/fetch_sel_chk.sv
module fetch_sel_chk #(
  parameter int NT = 8,
  parameter int FW = 8,
  localparam int TW = (NT > 1) ? $clog2(NT) : 1,
  localparam int SW = $clog2(FW + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    split_mode,
  input logic [NT-1:0] thr_valid,
  input logic [NT-1:0] thr_stall,
  input logic [NT-1:0] thr_imiss,
  input logic          g0_vld,
  input logic [TW-1:0] g0_tid,
  input logic [SW-1:0] g0_slots,
  input logic          g1_vld,
  input logic [TW-1:0] g1_tid,
  input logic [SW-1:0] g1_slots
);
  logic [NT-1:0] elig_q;
  logic [1:0]    split_q;

  always_ff @(posedge clk) begin
    elig_q  <= thr_valid & ~thr_stall & ~thr_imiss;
    split_q <= split_mode;
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!g0_vld && !g1_vld && g0_slots == '0 && g1_slots == '0));

  a_r2_first_eligible: assert property (@(posedge clk) disable iff (rst)
    g0_vld |-> elig_q[g0_tid]);

  a_r2_second_eligible: assert property (@(posedge clk) disable iff (rst)
    g1_vld |-> elig_q[g1_tid]);

  a_r8_single_only: assert property (@(posedge clk) disable iff (rst)
    (split_q == 2'd0 || split_q == 2'd3) |-> !g1_vld);

  a_r9_halves: assert property (@(posedge clk) disable iff (rst)
    (g1_vld && split_q == 2'd1) |->
      (g0_slots == SW'(FW / 2) && g1_slots == SW'(FW / 2)));

  a_r10_width_bound: assert property (@(posedge clk) disable iff (rst)
    g1_vld |-> (int'(g0_slots) + int'(g1_slots) <= FW));

  a_r11_distinct: assert property (@(posedge clk) disable iff (rst)
    g1_vld |-> (g0_vld && g0_tid != g1_tid));

  a_r11_lone_full: assert property (@(posedge clk) disable iff (rst)
    (g0_vld && !g1_vld) |-> g0_slots == SW'(FW));

  a_r11_none: assert property (@(posedge clk) disable iff (rst)
    (elig_q == '0) |-> (!g0_vld && !g1_vld));
endmodule

bind fetch_sel fetch_sel_chk #(.NT(NT), .FW(FW)) u_chk (
  .clk(clk), .rst(rst), .split_mode(split_mode),
  .thr_valid(thr_valid), .thr_stall(thr_stall), .thr_imiss(thr_imiss),
  .g0_vld(g0_vld), .g0_tid(g0_tid), .g0_slots(g0_slots),
  .g1_vld(g1_vld), .g1_tid(g1_tid), .g1_slots(g1_slots));

// File: tb/fetch_sel_test.sv
module fetch_sel_test;
  localparam int PERIOD = 10;
  localparam int NT = 8;
  localparam int FW = 8;
  localparam int CW = 5;
  localparam int TW = 3;
  localparam int SW = 4;
  localparam int CMAX = 31;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] key_mode = '0, split_mode = '0;
  logic [NT-1:0] thr_valid = '0, thr_stall = '0, thr_imiss = '0;
  logic [NT*SW-1:0] avail = '0;
  logic [NT-1:0] ic_inc = '0, ic_dec = '0, br_inc = '0, br_dec = '0;
  logic [NT-1:0] ms_inc = '0, ms_dec = '0;
  logic g0_vld, g1_vld;
  logic [TW-1:0] g0_tid, g1_tid;
  logic [SW-1:0] g0_slots, g1_slots;

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  int m_ic[NT], m_br[NT], m_ms[NT];
  int m_ptr;
  int e_v0, e_t0, e_s0, e_v1, e_t1, e_s1;
  bit e_ok[NT];

  always #(PERIOD/2) clk = ~clk;

  fetch_sel #(.NT(NT), .FW(FW), .CW(CW)) uut (
    .clk(clk), .rst(rst), .key_mode(key_mode), .split_mode(split_mode),
    .thr_valid(thr_valid), .thr_stall(thr_stall), .thr_imiss(thr_imiss),
    .avail(avail), .ic_inc(ic_inc), .ic_dec(ic_dec), .br_inc(br_inc),
    .br_dec(br_dec), .ms_inc(ms_inc), .ms_dec(ms_dec),
    .g0_vld(g0_vld), .g0_tid(g0_tid), .g0_slots(g0_slots),
    .g1_vld(g1_vld), .g1_tid(g1_tid), .g1_slots(g1_slots));

  function automatic int upd(int c, bit i, bit d);
    if (i && !d) return (c < CMAX) ? c + 1 : c;
    if (d && !i) return (c > 0) ? c - 1 : c;
    return c;
  endfunction

  // Reference model: evaluated right after a rising edge on the inputs
  // that were stable at that edge.
  task automatic model_edge();
    int key[NT];
    int best0, best1, sc, av0, av1;
    bit pair;
    e_v0 = 0; e_t0 = 0; e_s0 = 0; e_v1 = 0; e_t1 = 0; e_s1 = 0;
    for (int t = 0; t < NT; t++)
      e_ok[t] = thr_valid[t] && !thr_stall[t] && !thr_imiss[t];
    if (rst) begin
      for (int t = 0; t < NT; t++) begin m_ic[t] = 0; m_br[t] = 0; m_ms[t] = 0; end
      m_ptr = 0;
      return;
    end
    for (int t = 0; t < NT; t++)
      key[t] = (key_mode == 1) ? m_ic[t] : (key_mode == 2) ? m_br[t] :
               (key_mode == 3) ? m_ms[t] : 0;
    best0 = 1 << 30; best1 = 1 << 30;
    for (int t = 0; t < NT; t++) begin
      if (!e_ok[t]) continue;
      sc = key[t] * NT + ((t - m_ptr + NT) % NT);
      if (sc < best0) begin best0 = sc; e_t0 = t; e_v0 = 1; end
    end
    for (int t = 0; t < NT; t++) begin
      if (!e_ok[t] || (e_v0 && t == e_t0)) continue;
      sc = key[t] * NT + ((t - m_ptr + NT) % NT);
      if (sc < best1) begin best1 = sc; e_t1 = t; e_v1 = 1; end
    end
    pair = (split_mode == 1 || split_mode == 2) && e_v0 && e_v1;
    if (!pair) begin e_v1 = 0; e_t1 = 0; end
    if (e_v0) e_s0 = FW;
    if (pair && split_mode == 1) begin e_s0 = FW / 2; e_s1 = FW / 2; end
    if (pair && split_mode == 2) begin
      av0 = int'(avail[e_t0*SW +: SW]);
      av1 = int'(avail[e_t1*SW +: SW]);
      e_s0 = (av0 > FW) ? FW : av0;
      e_s1 = (av1 > FW - e_s0) ? FW - e_s0 : av1;
    end
    if (pair) m_ptr = (e_t1 + 1) % NT;
    else if (e_v0) m_ptr = (e_t0 + 1) % NT;
    if (!e_v0) e_t0 = 0;
    for (int t = 0; t < NT; t++) begin
      m_ic[t] = upd(m_ic[t], ic_inc[t], ic_dec[t]);
      m_br[t] = upd(m_br[t], br_inc[t], br_dec[t]);
      m_ms[t] = upd(m_ms[t], ms_inc[t], ms_dec[t]);
    end
  endtask

  // One clock: edge, model update, compare at the falling edge (R13).
  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    checks++;
    if (g0_vld !== e_v0[0] || int'(g0_tid) != e_t0 || int'(g0_slots) != e_s0 ||
        g1_vld !== e_v1[0] || int'(g1_tid) != e_t1 || int'(g1_slots) != e_s1) begin
      errors++;
      $display("FAIL %s: got g0=%0b/%0d/%0d g1=%0b/%0d/%0d expected g0=%0d/%0d/%0d g1=%0d/%0d/%0d",
               tag, g0_vld, g0_tid, g0_slots, g1_vld, g1_tid, g1_slots,
               e_v0, e_t0, e_s0, e_v1, e_t1, e_s1);
    end
    if (g0_vld) begin
      checks++;
      if (!e_ok[g0_tid]) begin
        errors++;
        $display("FAIL R2: granted thread %0d was ineligible, expected an eligible one", g0_tid);
      end
    end
  endtask

  task automatic quiet();
    ic_inc = '0; ic_dec = '0; br_inc = '0; br_dec = '0; ms_inc = '0; ms_dec = '0;
  endtask

  task automatic rand_pulses();
    ic_inc = NT'($urandom); ic_dec = NT'($urandom) & NT'($urandom);
    br_inc = NT'($urandom) & NT'($urandom); br_dec = NT'($urandom) & NT'($urandom);
    ms_inc = NT'($urandom) & NT'($urandom); ms_dec = NT'($urandom) & NT'($urandom);
  endtask

  task automatic rand_elig(int sparse);
    thr_valid = NT'($urandom);
    thr_stall = NT'($urandom) & NT'($urandom);
    thr_imiss = NT'($urandom) & NT'($urandom);
    if (sparse) thr_valid = thr_valid & NT'($urandom) & NT'($urandom);
    for (int t = 0; t < NT; t++) avail[t*SW +: SW] = SW'($urandom_range(0, 15));
  endtask

  task automatic do_reset();
    rst = 1'b1; quiet();
    repeat (3) step();
    rst = 1'b0;
  endtask

  initial begin
    // R1: reset state
    tag = "R1";
    thr_valid = '1;
    do_reset();
    // R13: first grant one edge after the inputs
    tag = "R13";
    thr_valid = 8'b0000_1000; split_mode = 2'd0; key_mode = 2'd0;
    step();
    // R3 and R8: rotation, single thread per cycle
    tag = "R3";
    thr_valid = '1;
    repeat (10) step();
    tag = "R8";
    split_mode = 2'd3;
    for (int i = 0; i < 30; i++) begin rand_elig(0); step(); end
    // R2: stall, invalid and instruction-miss flags
    tag = "R2";
    split_mode = 2'd1;
    for (int i = 0; i < 40; i++) begin rand_elig(0); step(); end
    // R7: equal counts after reset, ordering by the pointer
    tag = "R7";
    do_reset();
    thr_valid = '1; thr_stall = '0; thr_imiss = '0; key_mode = 2'd1;
    repeat (12) step();
    // R12: saturation, no underflow, cancellation
    tag = "R12";
    split_mode = 2'd0;
    quiet(); ic_inc[0] = 1'b1;
    repeat (40) step();
    quiet(); ic_inc[1] = 1'b1;
    repeat (31) step();
    quiet(); ic_dec[2] = 1'b1; ic_inc[3] = 1'b1; ic_dec[3] = 1'b1;
    for (int t = 4; t < NT; t++) ic_inc[t] = 1'b1;
    repeat (6) step();
    quiet(); ic_dec[0] = 1'b1;
    step();
    quiet(); ic_inc[2] = 1'b1;
    repeat (8) step();
    // R4, R5, R6: ranking policies under random traffic
    for (int m = 1; m <= 3; m++) begin
      key_mode = 2'(m);
      tag = (m == 1) ? "R4" : (m == 2) ? "R5" : "R6";
      for (int i = 0; i < 400; i++) begin
        split_mode = 2'($urandom_range(0, 3));
        rand_elig(0); rand_pulses(); step();
      end
    end
    // R9, R10, R11: split policies with few eligible threads
    quiet();
    for (int p = 0; p < 3; p++) begin
      tag = (p == 0) ? "R9" : (p == 1) ? "R10" : "R11";
      for (int i = 0; i < 300; i++) begin
        key_mode = 2'($urandom_range(0, 3));
        split_mode = (p == 0) ? 2'd1 : (p == 1) ? 2'd2 : 2'($urandom_range(1, 2));
        rand_elig(p == 2); rand_pulses(); step();
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule